// File: doc/BRIEF.md
# Adaptive Page Policy Auto-Precharge Decider

This block decides, for a read or write column command about to be sent to a DRAM bank, whether that command should close the row behind it (auto-precharge). The caller presents the request's rank, bank, row and channel tag, the count of column accesses already made to the open row, an optional per-row access limit, a page-policy mode, and a snapshot of a small pending-request queue. One clock later the block returns a single decision bit.

Two fixed policies keep the row open or close it every time. Two adaptive policies look at the pending queue: a pending entry for the same rank, bank and row (a hit) keeps the row open; a pending entry for the same rank and bank but a different row (a conflict) argues for closing it. The queue scan is fully parallel, with one comparator per slot, so the decision costs one registered stage regardless of queue depth.

Top module: `apd_top`

## Requirements
- R1: While rst_n is low, dec_valid and dec_autopre are 0, and both stay 0 on the first edge after a reset cycle.
- R2: dec_valid equals req_valid of the previous clock edge; when req_valid was 0, dec_autopre is 0.
- R3: With page_mode = 2 (close), dec_autopre is 1 for every request, whatever the queue holds.
- R4: When row_acc_limit is nonzero and row_acc_cnt >= row_acc_limit, dec_autopre is 1 in every mode.
- R5: A row_acc_limit of 0 disables the limit check, however large row_acc_cnt is.
- R6: With page_mode = 0 (open) and no limit forcing, dec_autopre is 0 whatever the queue holds.
- R7: A hit is a valid slot with equal rank, bank and row; in page_mode 1 (open-adaptive) or 3 (close-adaptive) without limit forcing, any hit makes dec_autopre 0.
- R8: A conflict is a valid slot with equal rank and bank but a different row; in open-adaptive mode with no hit and no forcing, dec_autopre is 1 exactly when a conflict exists.
- R9: In close-adaptive mode with no hit, dec_autopre is 1 even when no conflict exists.
- R10: Slots with q_valid = 0 or with a channel tag different from req_chan are neither hits nor conflicts; a slot that differs only in rank is neither.
- R11: When req_self_en is 1, the slot at index req_self_idx (the request's own entry) is excluded from the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A column command asks for a decision this cycle |
| req_rank | input | RANK_W | Request rank |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_chan | input | CHAN_W | Request channel tag |
| req_self_en | input | 1 | The request itself sits in the queue snapshot |
| req_self_idx | input | IDX_W | Slot index of the request's own entry |
| row_acc_cnt | input | CNT_W | Column accesses already made to the open row |
| row_acc_limit | input | CNT_W | Per-row access limit, 0 = none |
| page_mode | input | 2 | 0 open, 1 open-adaptive, 2 close, 3 close-adaptive |
| q_valid | input | SLOTS | Slot valid bits |
| q_rank | input | SLOTS*RANK_W | Slot ranks, slot i at [i*RANK_W +: RANK_W] |
| q_bank | input | SLOTS*BANK_W | Slot banks, packed the same way |
| q_row | input | SLOTS*ROW_W | Slot rows, packed the same way |
| q_chan | input | SLOTS*CHAN_W | Slot channel tags, packed the same way |
| dec_valid | output | 1 | Decision is valid (one cycle after req_valid) |
| dec_autopre | output | 1 | Auto-precharge the row with this command |

## Verification
Every mode is tried against four queue shapes: no matching slot, a hit only, a conflict only, and both, which separates the mode that ignores the queue, the one that always closes, and the two adaptive ones that differ only when the queue is empty of matches. Limit cases put the count just below, at and above the limit and use a zero limit with a large count, telling forcing apart from the mode decision. Directed patterns hide a would-be hit behind a cleared valid bit, a different channel tag, a different rank or the self index, each chosen so that wrongly counting it flips the output.

// File: rtl/apd_pkg.sv
package apd_pkg;

  typedef enum logic [1:0] {
    PG_OPEN        = 2'd0,
    PG_OPEN_ADAPT  = 2'd1,
    PG_CLOSE       = 2'd2,
    PG_CLOSE_ADAPT = 2'd3
  } page_mode_e;

  // Access limit reached: a zero limit means unlimited.
  function automatic logic limit_reached(input int unsigned cnt,
                                         input int unsigned lim);
    return (lim != 0) && (cnt >= lim);
  endfunction

  // Adaptive choice: keep open on any hit; otherwise close on a conflict,
  // or always when the policy leans toward closing.
  function automatic logic adaptive_close(input logic hit,
                                          input logic conf,
                                          input logic lean_close);
    return !hit && (conf || lean_close);
  endfunction

endpackage

// File: rtl/apd_slot_cmp.sv
module apd_slot_cmp #(
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CHAN_W = 1
) (
  input  logic              slot_vld,
  input  logic              slot_excl,
  input  logic [RANK_W-1:0] slot_rank,
  input  logic [BANK_W-1:0] slot_bank,
  input  logic [ROW_W-1:0]  slot_row,
  input  logic [CHAN_W-1:0] slot_chan,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [CHAN_W-1:0] req_chan,
  output logic              is_hit,
  output logic              is_conf
);
  logic eligible;
  logic same_bank;
  logic same_row;

  always_comb begin
    eligible  = slot_vld && !slot_excl && (slot_chan == req_chan);
    same_bank = (slot_rank == req_rank) && (slot_bank == req_bank);
    same_row  = (slot_row == req_row);
    is_hit    = eligible && same_bank && same_row;
    is_conf   = eligible && same_bank && !same_row;
  end
endmodule

// File: rtl/apd_queue_scan.sv
module apd_queue_scan #(
  parameter int SLOTS  = 8,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CHAN_W = 1,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]        q_valid,
  input  logic [SLOTS*RANK_W-1:0] q_rank,
  input  logic [SLOTS*BANK_W-1:0] q_bank,
  input  logic [SLOTS*ROW_W-1:0]  q_row,
  input  logic [SLOTS*CHAN_W-1:0] q_chan,
  input  logic [RANK_W-1:0]       req_rank,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [CHAN_W-1:0]       req_chan,
  input  logic                    self_en,
  input  logic [IDX_W-1:0]        self_idx,
  output logic                    any_hit,
  output logic                    any_conf
);
  logic [SLOTS-1:0] hit_vec;
  logic [SLOTS-1:0] conf_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic excl;
    assign excl = self_en && (self_idx == IDX_W'(i));
    apd_slot_cmp #(
      .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .CHAN_W(CHAN_W)
    ) u_cmp (
      .slot_vld (q_valid[i]),
      .slot_excl(excl),
      .slot_rank(q_rank[i*RANK_W +: RANK_W]),
      .slot_bank(q_bank[i*BANK_W +: BANK_W]),
      .slot_row (q_row[i*ROW_W +: ROW_W]),
      .slot_chan(q_chan[i*CHAN_W +: CHAN_W]),
      .req_rank (req_rank),
      .req_bank (req_bank),
      .req_row  (req_row),
      .req_chan (req_chan),
      .is_hit   (hit_vec[i]),
      .is_conf  (conf_vec[i])
    );
  end

  assign any_hit  = |hit_vec;
  assign any_conf = |conf_vec;
endmodule

// File: rtl/apd_policy.sv
module apd_policy
  import apd_pkg::*;
(
  input  page_mode_e mode,
  input  logic       forced,
  input  logic       any_hit,
  input  logic       any_conf,
  output logic       close_row
);
  always_comb begin
    if (forced) begin
      close_row = 1'b1;
    end else begin
      unique case (mode)
        PG_OPEN:        close_row = 1'b0;
        PG_CLOSE:       close_row = 1'b1;
        PG_OPEN_ADAPT:  close_row = adaptive_close(any_hit, any_conf, 1'b0);
        PG_CLOSE_ADAPT: close_row = adaptive_close(any_hit, any_conf, 1'b1);
        default:        close_row = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/apd_top.sv
module apd_top
  import apd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CHAN_W = 1,
  parameter int CNT_W  = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [RANK_W-1:0]       req_rank,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [CHAN_W-1:0]       req_chan,
  input  logic                    req_self_en,
  input  logic [IDX_W-1:0]        req_self_idx,
  input  logic [CNT_W-1:0]        row_acc_cnt,
  input  logic [CNT_W-1:0]        row_acc_limit,
  input  logic [1:0]              page_mode,
  input  logic [SLOTS-1:0]        q_valid,
  input  logic [SLOTS*RANK_W-1:0] q_rank,
  input  logic [SLOTS*BANK_W-1:0] q_bank,
  input  logic [SLOTS*ROW_W-1:0]  q_row,
  input  logic [SLOTS*CHAN_W-1:0] q_chan,
  output logic                    dec_valid,
  output logic                    dec_autopre
);
  // Named internal events, observed by the bound checker.
  logic lim_forced;
  logic any_hit;
  logic any_conf;
  logic close_row;

  assign lim_forced = limit_reached(32'(row_acc_cnt), 32'(row_acc_limit));

  apd_queue_scan #(
    .SLOTS(SLOTS), .RANK_W(RANK_W), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .CHAN_W(CHAN_W)
  ) u_scan (
    .q_valid (q_valid),
    .q_rank  (q_rank),
    .q_bank  (q_bank),
    .q_row   (q_row),
    .q_chan  (q_chan),
    .req_rank(req_rank),
    .req_bank(req_bank),
    .req_row (req_row),
    .req_chan(req_chan),
    .self_en (req_self_en),
    .self_idx(req_self_idx),
    .any_hit (any_hit),
    .any_conf(any_conf)
  );

  apd_policy u_policy (
    .mode     (page_mode_e'(page_mode)),
    .forced   (lim_forced),
    .any_hit  (any_hit),
    .any_conf (any_conf),
    .close_row(close_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_autopre <= 1'b0;
    end else begin
      dec_valid   <= req_valid;
      dec_autopre <= req_valid && close_row;
    end
  end
endmodule

// File: rtl/apd_checker.sv
module apd_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [CNT_W-1:0] row_acc_cnt,
  input logic [CNT_W-1:0] row_acc_limit,
  input logic [1:0]       page_mode,
  input logic             lim_forced,
  input logic             any_hit,
  input logic             any_conf,
  input logic             dec_valid,
  input logic             dec_autopre
);
  logic cnt_at_limit;
  assign cnt_at_limit = (row_acc_limit != '0) && (row_acc_cnt >= row_acc_limit);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (!dec_valid && !dec_autopre));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!dec_valid && !dec_autopre));

  // R3
  close_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && page_mode == 2'd2) |=> dec_autopre);

  // R4
  limit_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cnt_at_limit) |=> dec_autopre);

  // R6
  open_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && page_mode == 2'd0 && !lim_forced) |=> !dec_autopre);

  // R7
  hit_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && page_mode[0] && !lim_forced && any_hit) |=> !dec_autopre);

  // R8
  conflict_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && page_mode == 2'd1 && !lim_forced && !any_hit && any_conf)
      |=> dec_autopre);

  // R9
  close_adapt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && page_mode == 2'd3 && !any_hit) |=> dec_autopre);
endmodule

bind apd_top apd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .row_acc_cnt  (row_acc_cnt),
  .row_acc_limit(row_acc_limit),
  .page_mode    (page_mode),
  .lim_forced   (lim_forced),
  .any_hit      (any_hit),
  .any_conf     (any_conf),
  .dec_valid    (dec_valid),
  .dec_autopre  (dec_autopre)
);

// File: tb/sim_apd_top.sv
module sim_apd_top;
  localparam int SLOTS = 8, RANK_W = 2, BANK_W = 3, ROW_W = 14, CHAN_W = 1, CNT_W = 8;
  localparam int IDX_W = 3;
  localparam int NVEC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [RANK_W-1:0] req_rank = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [CHAN_W-1:0] req_chan = '0;
  logic req_self_en = 1'b0;
  logic [IDX_W-1:0] req_self_idx = '0;
  logic [CNT_W-1:0] row_acc_cnt = '0;
  logic [CNT_W-1:0] row_acc_limit = '0;
  logic [1:0] page_mode = '0;
  logic [SLOTS-1:0] q_valid = '0;
  logic [SLOTS*RANK_W-1:0] q_rank = '0;
  logic [SLOTS*BANK_W-1:0] q_bank = '0;
  logic [SLOTS*ROW_W-1:0]  q_row = '0;
  logic [SLOTS*CHAN_W-1:0] q_chan = '0;
  logic dec_valid, dec_autopre;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  apd_top #(.SLOTS(SLOTS), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
            .CHAN_W(CHAN_W), .CNT_W(CNT_W)) u0 (.*);

  // Vector: [20:19] mode, [18:11] count, [10:3] limit, [2:1] queue shape
  // (bit0 hit present, bit1 conflict present), [0] expected dec_autopre.
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 8'd0, 8'd0, 2'd0, 1'b0}, {2'd0, 8'd0, 8'd0, 2'd1, 1'b0},
    {2'd0, 8'd0, 8'd0, 2'd2, 1'b0}, {2'd0, 8'd0, 8'd0, 2'd3, 1'b0},
    {2'd1, 8'd0, 8'd0, 2'd0, 1'b0}, {2'd1, 8'd0, 8'd0, 2'd1, 1'b0},
    {2'd1, 8'd0, 8'd0, 2'd2, 1'b1}, {2'd1, 8'd0, 8'd0, 2'd3, 1'b0},
    {2'd2, 8'd0, 8'd0, 2'd0, 1'b1}, {2'd2, 8'd0, 8'd0, 2'd1, 1'b1},
    {2'd2, 8'd0, 8'd0, 2'd2, 1'b1}, {2'd2, 8'd0, 8'd0, 2'd3, 1'b1},
    {2'd3, 8'd0, 8'd0, 2'd0, 1'b1}, {2'd3, 8'd0, 8'd0, 2'd1, 1'b0},
    {2'd3, 8'd0, 8'd0, 2'd2, 1'b1}, {2'd3, 8'd0, 8'd0, 2'd3, 1'b0},
    {2'd1, 8'd4, 8'd4, 2'd1, 1'b1}, {2'd0, 8'd3, 8'd4, 2'd1, 1'b0},
    {2'd0, 8'd5, 8'd4, 2'd0, 1'b1}, {2'd0, 8'd200, 8'd0, 2'd1, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_slot(input int i, input logic v, input int rk, input int bk,
                          input int rw, input int ch);
    q_valid[i] = v;
    q_rank[i*RANK_W +: RANK_W] = RANK_W'(rk);
    q_bank[i*BANK_W +: BANK_W] = BANK_W'(bk);
    q_row[i*ROW_W +: ROW_W]    = ROW_W'(rw);
    q_chan[i*CHAN_W +: CHAN_W] = CHAN_W'(ch);
  endtask

  // Request is rank 1, bank 2, row 100, channel 0. Two fillers never match.
  task automatic load_shape(input logic [1:0] shape);
    for (int i = 0; i < SLOTS; i++) set_slot(i, 1'b0, 0, 0, 0, 0);
    set_slot(0, 1'b1, 1, 5, 100, 0);
    set_slot(1, 1'b1, 0, 2, 100, 0);
    if (shape[0]) set_slot(3, 1'b1, 1, 2, 100, 0);
    if (shape[1]) set_slot(5, 1'b1, 1, 2, 200, 0);
  endtask

  // Drive at a falling edge, check at the next falling edge (one register).
  task automatic run(input logic [1:0] md, input int cnt, input int lim,
                     input string req, input logic exp);
    @(negedge clk);
    req_valid = 1'b1; req_rank = 1; req_bank = 2; req_row = 100; req_chan = 0;
    page_mode = md; row_acc_cnt = CNT_W'(cnt); row_acc_limit = CNT_W'(lim);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, dec_valid, 1'b1);
    check(req, dec_autopre, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    // R1 reset state
    req_valid = 1'b1; page_mode = 2'd2;
    repeat (3) @(negedge clk);
    check("R1 valid", dec_valid, 1'b0);
    check("R1 autopre", dec_autopre, 1'b0);
    req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle valid", dec_valid, 1'b0);

    // Table: R3 close, R6 open, R7 hit, R8 conflict, R9 close-adaptive,
    // R4 limit forcing, R5 zero limit.
    for (int v = 0; v < NVEC; v++) begin
      load_shape(VEC[v][2:1]);
      tag = $sformatf("R3/R4/R5/R6/R7/R8/R9 vec%0d", v);
      run(VEC[v][20:19], int'(VEC[v][18:11]), int'(VEC[v][10:3]), tag, VEC[v][0]);
    end

    // R2: idle cycle after a closing decision returns low
    load_shape(2'd0);
    run(2'd2, 0, 0, "R2 close", 1'b1);
    @(negedge clk);
    check("R2 idle valid", dec_valid, 1'b0);
    check("R2 idle autopre", dec_autopre, 1'b0);

    // R10: hit slot invalid -> conflict alone closes in open-adaptive
    load_shape(2'd3); q_valid[3] = 1'b0;
    run(2'd1, 0, 0, "R10 invalid hit", 1'b1);
    // R10: hit on other channel ignored
    load_shape(2'd3); q_chan[3] = 1'b1;
    run(2'd1, 0, 0, "R10 chan hit", 1'b1);
    // R10: conflict on other channel ignored
    load_shape(2'd2); q_chan[5] = 1'b1;
    run(2'd1, 0, 0, "R10 chan conf", 1'b0);
    // R10: conflict differing only in rank is not a conflict
    load_shape(2'd2); q_rank[5*RANK_W +: RANK_W] = 2'd3;
    run(2'd1, 0, 0, "R10 rank conf", 1'b0);
    // R11: own entry excluded -> close-adaptive closes
    load_shape(2'd1); req_self_en = 1'b1; req_self_idx = 3'd3;
    run(2'd3, 0, 0, "R11 self excluded", 1'b1);
    // R11: self index elsewhere -> hit counts
    req_self_idx = 3'd6;
    run(2'd3, 0, 0, "R11 other index", 1'b0);
    req_self_en = 1'b0;

    // R4: limit at top of range, R5 with close-adaptive hit
    load_shape(2'd1);
    run(2'd3, 255, 255, "R4 max limit", 1'b1);
    run(2'd3, 255, 0, "R5 zero limit", 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule